// File: doc/BRIEF.md
# Octal Common-Start Counting Time Digitizer

This block measures eight time intervals against one shared reference. A strobe on the shared start input resets a free-running cycle counter to zero and opens a conversion window. Each of the eight lanes then records the elapsed cycle count when its own stop strobe arrives. A lane that sees no stop before the full-scale count is reached is flagged as overflowed. All inputs are synchronous single-cycle strobes.

A conversion ends when every lane has either stopped or reached full scale. A fast clear aborts the conversion at any point. A common-stop strobe stops every lane that is still open in the same cycle. A test strobe starts an internal conversion that stops all lanes at about 80% of full scale. When a conversion ends with no lane stopped, the block reports itself as empty and withholds its end-of-conversion request, unless a configuration input turns that suppression off.

Top module: `tdc_octal`

## Requirements
- R1: A stop strobe sampled k clock edges after the start strobe was sampled stores the value k in that lane. The 11-bit value of lane i is `val_o[i*11 +: 11]`, and the counter starts again from zero on every accepted start.
- R2: A stop strobe has no effect on the stored values unless a conversion is running. This includes stops sampled before any start and a stop sampled in the same cycle as the start.
- R3: Only the first stop after a start is stored in a lane. Later stops to that lane leave its value unchanged.
- R4: A common-stop strobe stores the current elapsed count in every lane that has not yet stopped, in the same cycle. Lanes that have already stopped keep their values.
- R5: FULL_SCALE (default 2047) bounds the conversion. A stop at exactly FULL_SCALE cycles stores FULL_SCALE with `ovf_o[i]`=0. A lane with no stop by then gets `ovf_o[i]`=1 and the value FULL_SCALE.
- R6: The conversion ends in the cycle in which every lane has stopped, or in which full scale is reached, whichever comes first. `eoc_o` stays low before that.
- R7: A fast clear, in any state, returns the block to idle. It zeroes all values and overflow flags and drops `eoc_o` and `empty_o`. A fast clear takes priority over a start or test strobe in the same cycle.
- R8: A test strobe accepted while not converting starts a conversion. In that conversion every lane that is still open stops at TEST_AT = floor(FULL_SCALE*4/5) cycles, which is 1637 by default. A test strobe during a running conversion is ignored.
- R9: At the end of a conversion in which no lane stopped, `empty_o`=1, and `eoc_o` is 0 when `supp_dis_i`=0 and 1 when `supp_dis_i`=1. When at least one lane stopped, `empty_o`=0 and `eoc_o`=1.
- R10: A start strobe during a running conversion is ignored. A start after the end of a conversion begins a new one, clears the old results and drops `eoc_o`.
- R11: After reset all values and overflow flags are zero, and `eoc_o` and `empty_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Shared start strobe |
| stop_i | input | 8 | Per-lane stop strobes |
| com_stop_i | input | 1 | Stop strobe for all lanes |
| fclr_i | input | 1 | Fast clear strobe |
| test_i | input | 1 | Internal test conversion request |
| supp_dis_i | input | 1 | 1 disables empty-module suppression of `eoc_o` |
| val_o | output | 88 | Per-lane 11-bit elapsed counts, lane i at bits i*11 +: 11 |
| ovf_o | output | 8 | Per-lane full-scale overflow flags |
| empty_o | output | 1 | Conversion ended with no lane stopped |
| eoc_o | output | 1 | End-of-conversion request |

## Verification
Several properties are checked by assertions on every cycle. A stopped lane keeps its value. Stops outside a conversion change nothing. A lane is never both stopped and overflowed, and an overflowed lane holds the full-scale value. The counter advances exactly once per cycle while running and never passes full scale. A full-scale cycle always ends the conversion, and a fast clear always leads to idle. Other behaviours can only be shown by the bench's scenarios. These are the exact values stored for given start-to-stop distances, the common-stop and test-stop instants, the rule that a restart is ignored mid-conversion, and the empty-module suppression seen at the outputs.

// File: rtl/tdc_pkg.sv
// Shared types for the octal counting time digitizer.
package tdc_pkg;

    // Conversion phase of the shared timebase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tdc_state_e;

endpackage

// File: rtl/tdc_timebase.sv
// Shared timebase and conversion sequencer.
// Owns the elapsed-cycle counter, which is cleared on an accepted start or
// test strobe, and the idle/run/done phase. It also generates the full-scale
// and internal test-stop instants.
// Assumes all strobes are synchronous, and that FULL_SCALE is at least 2 and
// fits in CNT_W bits.
module tdc_timebase #(
    parameter int CNT_W      = 11,
    parameter int FULL_SCALE = 2047,
    parameter int TEST_AT    = 1637
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             test_i,
    input  logic             fclr_i,
    input  logic             all_fin_i,
    output logic             arm_o,
    output logic             run_o,
    output logic             done_o,
    output logic             last_o,
    output logic             tst_stop_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    import tdc_pkg::*;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FULL_SCALE - 1);
    localparam logic [CNT_W-1:0] TEST_CNT = CNT_W'(TEST_AT - 1);

    tdc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmode_q;

    // Decode of the accept, full-scale and test-stop conditions.
    always_comb begin
        run_o      = (state_q == ST_RUN);
        done_o     = (state_q == ST_DONE);
        arm_o      = !fclr_i && !run_o && (start_i || test_i);
        last_o     = run_o && (cnt_q == LAST_CNT);
        tst_stop_o = run_o && tmode_q && (cnt_q == TEST_CNT);
        cnt_nxt_o  = cnt_q + 1'b1;
    end

    // Phase, counter and test-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmode_q <= 1'b0;
        end else if (fclr_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmode_q <= 1'b0;
        end else if (arm_o) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            tmode_q <= test_i;
        end else if (run_o) begin
            cnt_q <= cnt_nxt_o;
            if (last_o || all_fin_i) begin
                state_q <= ST_DONE;
            end
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> (cnt_q < CNT_W'(FULL_SCALE)));

    // R6
    fs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !fclr_i) |=> (state_q == ST_DONE));

    // R7
    fclr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fclr_i |=> (state_q == ST_IDLE));

    // R10
    run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !fclr_i && !last_o && !all_fin_i)
            |=> (run_o && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tdc_lane.sv
// One measurement lane.
// When a conversion is running, the lane captures the next elapsed count on
// its first stop. If no stop arrives before the full-scale cycle, it flags
// overflow instead.
// Assumes arm_i, run_i and last_i come from the shared timebase.
module tdc_lane #(
    parameter int CNT_W      = 11,
    parameter int FULL_SCALE = 2047
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             arm_i,
    input  logic             run_i,
    input  logic             last_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic [CNT_W-1:0] val_o,
    output logic             ovf_o,
    output logic             hit_o,
    output logic             fin_o
);
    localparam logic [CNT_W-1:0] FS_VAL = CNT_W'(FULL_SCALE);

    logic [CNT_W-1:0] val_q;
    logic             hit_q;
    logic             ovf_q;
    logic             open_w;

    // The lane is open while running and not yet stopped or overflowed.
    always_comb begin
        open_w = run_i && !hit_q && !ovf_q;
        fin_o  = hit_q || ovf_q || (open_w && stop_i);
        val_o  = val_q;
        ovf_o  = ovf_q;
        hit_o  = hit_q;
    end

    // Capture of the first stop, or of the full-scale overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || arm_i) begin
            val_q <= '0;
            hit_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (open_w && stop_i) begin
            val_q <= cnt_nxt_i;
            hit_q <= 1'b1;
        end else if (open_w && last_i) begin
            val_q <= FS_VAL;
            ovf_q <= 1'b1;
        end
    end

    // R3
    first_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !clr_i && !arm_i) |=> (hit_q && $stable(val_q)));

    // R2
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i && !arm_i) |=> ($stable(val_q) && $stable(hit_q)));

    // R5
    hit_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_q && ovf_q));

    // R5
    ovf_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (val_q == FS_VAL));

endmodule

// File: rtl/tdc_octal.sv
// Octal common-start counting time digitizer, top level.
// Combines the shared timebase with NUM_CH lanes. It routes the per-lane,
// common and internal test stops, and forms the empty status and the
// end-of-conversion request with optional empty-module suppression.
// Assumes every input is a single-cycle synchronous strobe.
module tdc_octal #(
    parameter int NUM_CH     = 8,
    parameter int CNT_W      = 11,
    parameter int FULL_SCALE = 2047
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NUM_CH-1:0]       stop_i,
    input  logic                    com_stop_i,
    input  logic                    fclr_i,
    input  logic                    test_i,
    input  logic                    supp_dis_i,
    output logic [NUM_CH*CNT_W-1:0] val_o,
    output logic [NUM_CH-1:0]       ovf_o,
    output logic                    empty_o,
    output logic                    eoc_o
);
    localparam int TEST_AT = (FULL_SCALE * 4) / 5;

    logic             arm_w;
    logic             run_w;
    logic             done_w;
    logic             last_w;
    logic             tst_stop_w;
    logic [CNT_W-1:0] cnt_nxt_w;
    logic [NUM_CH-1:0] hit_w;
    logic [NUM_CH-1:0] fin_w;
    logic             all_fin_w;
    logic             any_hit_w;

    tdc_timebase #(
        .CNT_W      (CNT_W),
        .FULL_SCALE (FULL_SCALE),
        .TEST_AT    (TEST_AT)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .test_i     (test_i),
        .fclr_i     (fclr_i),
        .all_fin_i  (all_fin_w),
        .arm_o      (arm_w),
        .run_o      (run_w),
        .done_o     (done_w),
        .last_o     (last_w),
        .tst_stop_o (tst_stop_w),
        .cnt_nxt_o  (cnt_nxt_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        tdc_lane #(
            .CNT_W      (CNT_W),
            .FULL_SCALE (FULL_SCALE)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (fclr_i),
            .arm_i     (arm_w),
            .run_i     (run_w),
            .last_i    (last_w),
            .stop_i    (stop_i[g] || com_stop_i || tst_stop_w),
            .cnt_nxt_i (cnt_nxt_w),
            .val_o     (val_o[g*CNT_W +: CNT_W]),
            .ovf_o     (ovf_o[g]),
            .hit_o     (hit_w[g]),
            .fin_o     (fin_w[g])
        );
    end

    // Completion, empty status and suppressed end-of-conversion request.
    always_comb begin
        all_fin_w = &fin_w;
        any_hit_w = |hit_w;
        empty_o   = done_w && !any_hit_w;
        eoc_o     = done_w && (any_hit_w || supp_dis_i);
    end

    // R9
    empty_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (eoc_o == supp_dis_i));

    // R6
    eoc_all_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> ((hit_w | ovf_o) == {NUM_CH{1'b1}}));

endmodule

// File: tb/tb_tdc_octal.sv
// Directed bench for tdc_octal: one task per scenario.
// Inputs change on falling edges and outputs are sampled on falling edges.
module tb_tdc_octal;
    localparam int NUM_CH = 8;
    localparam int CNT_W  = 11;
    localparam int FS     = 2047;
    localparam int TST    = (FS * 4) / 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [NUM_CH-1:0]       stop_i = '0;
    logic                    com_stop_i = 1'b0;
    logic                    fclr_i = 1'b0;
    logic                    test_i = 1'b0;
    logic                    supp_dis_i = 1'b0;
    logic [NUM_CH*CNT_W-1:0] val_o;
    logic [NUM_CH-1:0]       ovf_o;
    logic                    empty_o;
    logic                    eoc_o;

    int checks = 0;
    int errors = 0;

    tdc_octal #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .FULL_SCALE(FS)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .com_stop_i(com_stop_i), .fclr_i(fclr_i), .test_i(test_i),
        .supp_dis_i(supp_dis_i), .val_o(val_o), .ovf_o(ovf_o),
        .empty_o(empty_o), .eoc_o(eoc_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lane(input int i);
        return int'(val_o[i*CNT_W +: CNT_W]);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle strobe on the selected inputs, sampled at the next rising edge.
    task automatic pulse(input logic st, input logic [NUM_CH-1:0] sp,
                         input logic cs, input logic fc, input logic ts);
        start_i = st; stop_i = sp; com_stop_i = cs; fclr_i = fc; test_i = ts;
        @(negedge clk);
        start_i = 0; stop_i = '0; com_stop_i = 0; fclr_i = 0; test_i = 0;
    endtask

    task automatic do_clear();
        pulse(0, '0, 0, 1, 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NUM_CH; i++) check("R11 val", lane(i), 0);
        check("R11 ovf", int'(ovf_o), 0);
        check("R11 eoc", int'(eoc_o), 0);
        check("R11 empty", int'(empty_o), 0);
    endtask

    task automatic t_early_stop();
        pulse(0, 8'hFF, 1, 0, 0);
        for (int i = 0; i < NUM_CH; i++) check("R2 stop before start", lane(i), 0);
        pulse(1, 8'h01, 0, 0, 0);
        idle(19);
        pulse(0, 8'h01, 0, 0, 0);
        check("R2 same-cycle stop ignored", lane(0), 20);
        pulse(0, '0, 1, 0, 0);
        do_clear();
    endtask

    task automatic t_distinct();
        pulse(1, '0, 0, 0, 0);
        for (int i = 0; i < NUM_CH; i++) begin
            idle(4);
            if (i == 3) pulse(0, 8'h09, 0, 0, 0);
            else pulse(0, 8'(1 << i), 0, 0, 0);
            if (i == 6) check("R6 eoc low before last stop", int'(eoc_o), 0);
        end
        for (int i = 0; i < NUM_CH; i++) check("R1 lane value", lane(i), 5 * (i + 1));
        check("R3 second stop ignored", lane(0), 5);
        check("R6 eoc after all stopped", int'(eoc_o), 1);
        check("R9 not empty", int'(empty_o), 0);
    endtask

    task automatic t_common();
        pulse(1, '0, 0, 0, 0);
        idle(9);
        pulse(0, 8'h04, 0, 0, 0);
        idle(19);
        pulse(0, '0, 1, 0, 0);
        for (int i = 0; i < NUM_CH; i++)
            check("R4 common stop", lane(i), (i == 2) ? 10 : 30);
        check("R4 eoc", int'(eoc_o), 1);
    endtask

    task automatic t_restart();
        pulse(1, '0, 0, 0, 0);
        check("R10 eoc drops on new start", int'(eoc_o), 0);
        idle(9);
        pulse(1, '0, 0, 0, 0);
        idle(9);
        pulse(0, '0, 1, 0, 0);
        check("R10 mid-run start ignored", lane(3), 20);
        pulse(1, '0, 0, 0, 0);
        idle(6);
        pulse(0, '0, 1, 0, 0);
        check("R10 start after done", lane(3), 7);
    endtask

    task automatic t_full_scale();
        pulse(1, '0, 0, 0, 0);
        idle(FS - 1);
        pulse(0, 8'h20, 0, 0, 0);
        check("R5 stop at full scale", lane(5), FS);
        check("R5 ovf pattern", int'(ovf_o), 8'hDF);
        check("R5 overflow value", lane(0), FS);
        check("R6 eoc at full scale", int'(eoc_o), 1);
    endtask

    task automatic t_empty();
        pulse(1, '0, 0, 0, 0);
        idle(FS - 1);
        check("R6 eoc low before full scale", int'(eoc_o), 0);
        idle(1);
        check("R9 empty", int'(empty_o), 1);
        check("R9 eoc suppressed", int'(eoc_o), 0);
        check("R5 all overflow", int'(ovf_o), 8'hFF);
        supp_dis_i = 1'b1;
        #1;
        check("R9 suppression disabled", int'(eoc_o), 1);
        supp_dis_i = 1'b0;
    endtask

    task automatic t_fast_clear();
        do_clear();
        check("R7 clear drops eoc", int'(eoc_o), 0);
        check("R7 clear drops empty", int'(empty_o), 0);
        check("R7 clear ovf", int'(ovf_o), 0);
        pulse(1, '0, 0, 0, 0);
        idle(3);
        pulse(0, 8'h02, 0, 0, 0);
        idle(5);
        pulse(0, '0, 0, 1, 0);
        check("R7 abort clears value", lane(1), 0);
        pulse(1, '0, 0, 1, 0);
        idle(4);
        pulse(0, '0, 1, 0, 0);
        check("R7 clear beats start", lane(4), 0);
        check("R7 still idle", int'(eoc_o), 0);
    endtask

    task automatic t_test();
        pulse(0, '0, 0, 0, 1);
        idle(TST);
        for (int i = 0; i < NUM_CH; i++) check("R8 test stop", lane(i), TST);
        check("R8 eoc", int'(eoc_o), 1);
        pulse(1, '0, 0, 0, 0);
        idle(9);
        pulse(0, '0, 0, 0, 1);
        idle(1700 - 11);
        check("R8 test during run ignored", lane(6), 0);
        check("R8 no eoc", int'(eoc_o), 0);
        do_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_early_stop();
        t_distinct();
        t_common();
        t_restart();
        t_full_scale();
        t_empty();
        t_fast_clear();
        t_test();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule